// File: doc/BRIEF.md
# Sixteen-Bit Execution Unit with Barrel Shifter

This block is the combinational arithmetic, logic and shift stage of a small 16-bit processor core. Operand A always comes from the first source register. Operand B comes from the second source register or from an immediate that has already been extended upstream. A 4-bit operation code picks which function drives the single 16-bit result. The block holds no state, so the result follows the inputs within the same cycle.

The function set covers several jobs:
- Reversed subtraction, which suits immediate-minus-register instructions.
- A signed comparison family that returns 0 or 1.
- An unsigned carry test.
- A full bit reversal.
- A byte merge that builds a constant eight bits at a time.
- A pass-through of B for load-immediate instructions.

Operand selection, branch conditions and register writeback belong to the surrounding pipeline.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (add) gives A + B modulo 2^16.
- R2: Code 1 (reversed subtract) gives B − A modulo 2^16, never A − B.
- R3: Code 2 gives A | B and code 3 gives A & B.
- R4: Code 4 rotates A left and code 6 rotates A right, both by B[3:0]. Bits of B above bit 3 have no effect, and an amount of 0 returns A unchanged.
- R5: Code 5 shifts A left by B[3:0] and fills with zeros. Code 7 shifts A right by B[3:0] and fills with copies of A[15].
- R6: Code 8 gives 16'h0001 when A equals B and 16'h0000 otherwise.
- R7: Code 9 gives 16'h0001 when A < B and code 10 gives 16'h0001 when A ≤ B, otherwise 16'h0000. Both compare as two's complement and stay correct at the extremes (16'h8000 < 16'h7FFF holds).
- R8: Code 11 gives 16'h0001 when the unsigned sum A + B carries out of bit 15, otherwise 16'h0000.
- R9: Code 12 gives A with its bits mirrored: output bit i equals A[15−i]. B has no effect.
- R10: Code 13 gives {A[7:0], B[7:0]}, which is A shifted left by eight with the low byte of B placed in the low byte.
- R11: Code 14 passes B through unchanged. The unused code 15 gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code, values as listed in the requirements |
| a_i | input | 16 | First operand, from the first source register |
| b_i | input | 16 | Second operand, from a register or an extended immediate |
| result_o | output | 16 | Result of the selected operation |

## Verification
The bench goes after the signed comparison at the two extremes. A design that compares by subtracting at 16 bits would overflow there and report 16'h8000 as larger than 16'h7FFF.

It uses shift amounts whose upper bits are set. A shifter that reads all of B would then return zero or a wrong rotation.

It checks reversed subtraction with a nonzero A. A design with the operands swapped would return the negated difference.

It also checks the fill bit of the arithmetic right shift, carry at exactly 16'h8000 + 16'h8000, the mirror pattern of the bit reversal, and the unused code. Random operands are then compared against a bench model written independently of the RTL.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W  = 16;
    localparam int OP_W    = 4;
    localparam int BYTE_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_RSUB  = 4'd1,
        OP_OR    = 4'd2,
        OP_AND   = 4'd3,
        OP_ROL   = 4'd4,
        OP_SLL   = 4'd5,
        OP_ROR   = 4'd6,
        OP_SRA   = 4'd7,
        OP_SEQ   = 4'd8,
        OP_SLT   = 4'd9,
        OP_SLE   = 4'd10,
        OP_SCO   = 4'd11,
        OP_BREV  = 4'd12,
        OP_BMRG  = 4'd13,
        OP_PASSB = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_ROL = 2'd0,
        SH_SLL = 2'd1,
        SH_ROR = 2'd2,
        SH_SRA = 2'd3
    } shift_mode_e;

    typedef struct packed {
        logic eq;
        logic lt;
        logic carry;
    } cmp_flags_t;

    function automatic logic [DATA_W-1:0] flag_word(input logic f);
        return {{(DATA_W-1){1'b0}}, f};
    endfunction

    function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] rsub_o,
    output cmp_flags_t   flags_o
);
    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] usum;
    logic [EXT_W-1:0] sdiff;

    always_comb begin
        usum   = {1'b0, a_i} + {1'b0, b_i};
        sum_o  = usum[W-1:0];
        rsub_o = b_i + ~a_i + {{(W-1){1'b0}}, 1'b1};
        // sign-extended difference cannot overflow at W+1 bits
        sdiff  = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        flags_o.eq    = (a_i == b_i);
        flags_o.lt    = sdiff[EXT_W-1];
        flags_o.carry = usum[EXT_W-1];
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]         val_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  shift_mode_e          mode_i,
    output logic [W-1:0]         val_o
);
    localparam int STAGES = $clog2(W);

    logic [W-1:0] stg [0:STAGES];

    assign stg[0] = val_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            unique case (mode_i)
                SH_ROL:  moved = {stg[k][W-1-D:0], stg[k][W-1:W-D]};
                SH_SLL:  moved = {stg[k][W-1-D:0], {D{1'b0}}};
                SH_ROR:  moved = {stg[k][D-1:0], stg[k][W-1:D]};
                SH_SRA:  moved = {{D{stg[k][W-1]}}, stg[k][W-1:D]};
                default: moved = stg[k];
            endcase
        end
        assign stg[k+1] = amt_i[k] ? moved : stg[k];
    end

    assign val_o = stg[STAGES];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] or_o,
    output logic [W-1:0] and_o,
    output logic [W-1:0] brev_o,
    output logic [W-1:0] bmrg_o
);
    always_comb begin
        or_o   = a_i | b_i;
        and_o  = a_i & b_i;
        brev_o = mirror(a_i);
        bmrg_o = {a_i[W-BW-1:0], b_i[BW-1:0]};
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    result_o
);
    localparam int AMT_W = $clog2(W);

    alu_op_e      op;
    logic [W-1:0] sum, rsub, orv, andv, brev, bmrg, shv;
    cmp_flags_t   flags;
    shift_mode_e  smode;

    assign op    = alu_op_e'(op_i);
    assign smode = shift_mode_e'(op_i[1:0]);

    alu16_arith #(.W(W)) u_arith (
        .a_i(a_i), .b_i(b_i), .sum_o(sum), .rsub_o(rsub), .flags_o(flags)
    );

    alu16_shift #(.W(W)) u_shift (
        .val_i(a_i), .amt_i(b_i[AMT_W-1:0]), .mode_i(smode), .val_o(shv)
    );

    alu16_logic #(.W(W), .BW(BYTE_W)) u_logic (
        .a_i(a_i), .b_i(b_i), .or_o(orv), .and_o(andv),
        .brev_o(brev), .bmrg_o(bmrg)
    );

    always_comb begin
        unique case (op)
            OP_ADD:   result_o = sum;
            OP_RSUB:  result_o = rsub;
            OP_OR:    result_o = orv;
            OP_AND:   result_o = andv;
            OP_ROL, OP_SLL, OP_ROR, OP_SRA:
                      result_o = shv;
            OP_SEQ:   result_o = flag_word(flags.eq);
            OP_SLT:   result_o = flag_word(flags.lt);
            OP_SLE:   result_o = flag_word(flags.lt | flags.eq);
            OP_SCO:   result_o = flag_word(flags.carry);
            OP_BREV:  result_o = brev;
            OP_BMRG:  result_o = bmrg;
            OP_PASSB: result_o = b_i;
            default:  result_o = '0;
        endcase
    end
endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
    import alu16_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] result_o
);
    always_comb begin
        if (op_i == OP_ADD)
            a_r1_add_inverse: assert (result_o - b_i == a_i);
        if (op_i == OP_RSUB)
            a_r2_rsub_inverse: assert (result_o + a_i == b_i);
        if (op_i == OP_ROL || op_i == OP_ROR)
            a_r4_rot_keeps_ones: assert ($countones(result_o) == $countones(a_i));
        if (op_i == OP_SLL && b_i[3:0] != 4'd0)
            a_r5_sll_zero_lsb: assert (result_o[0] == 1'b0);
        if (op_i == OP_SRA)
            a_r5_sra_keeps_sign: assert (result_o[DATA_W-1] == a_i[DATA_W-1]);
        if (op_i >= OP_SEQ && op_i <= OP_SCO)
            a_r6_flag_upper_zero: assert (result_o[DATA_W-1:1] == '0);
        if (op_i == OP_SLT && a_i == b_i)
            a_r7_slt_not_equal: assert (result_o == 16'h0000);
        if (op_i == OP_SLE && a_i == b_i)
            a_r7_sle_equal: assert (result_o == 16'h0001);
        if (op_i == OP_BREV)
            a_r9_brev_ends: assert (result_o[0] == a_i[DATA_W-1]
                                    && $countones(result_o) == $countones(a_i));
        if (op_i == OP_BMRG)
            a_r10_merge_low: assert (result_o[7:0] == b_i[7:0]);
        if (op_i == OP_NONE)
            a_r11_unused_zero: assert (result_o == '0);
    end
endmodule

bind alu16_core alu16_core_chk u_chk (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .result_o(result_o)
);

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op;
    logic [15:0] a, b;
    logic [15:0] res;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu16_core dut_i (.op_i(op), .a_i(a), .b_i(b), .result_o(res));

    localparam int NV = 28;
    // {op, a, b, expected}
    localparam logic [51:0] VEC [NV] = '{
        {4'd0,  16'h1234, 16'h1111, 16'h2345},   // R1
        {4'd0,  16'hFFFF, 16'h0001, 16'h0000},   // R1
        {4'd1,  16'h0003, 16'h0010, 16'h000D},   // R2
        {4'd1,  16'h0001, 16'h0000, 16'hFFFF},   // R2
        {4'd2,  16'hF0F0, 16'h0F00, 16'hFFF0},   // R3
        {4'd3,  16'hF0F0, 16'h3C3C, 16'h3030},   // R3
        {4'd4,  16'h8001, 16'h0001, 16'h0003},   // R4
        {4'd4,  16'h1234, 16'hFFF4, 16'h2341},   // R4
        {4'd6,  16'h0001, 16'h0001, 16'h8000},   // R4
        {4'd6,  16'h1234, 16'h0010, 16'h1234},   // R4
        {4'd5,  16'h8001, 16'h0001, 16'h0002},   // R5
        {4'd5,  16'hFFFF, 16'h000F, 16'h8000},   // R5
        {4'd7,  16'h8000, 16'h000F, 16'hFFFF},   // R5
        {4'd7,  16'h7FF0, 16'h0004, 16'h07FF},   // R5
        {4'd8,  16'h5A5A, 16'h5A5A, 16'h0001},   // R6
        {4'd8,  16'h5A5A, 16'h5A5B, 16'h0000},   // R6
        {4'd9,  16'h8000, 16'h7FFF, 16'h0001},   // R7
        {4'd9,  16'h7FFF, 16'h8000, 16'h0000},   // R7
        {4'd10, 16'hFFFF, 16'hFFFF, 16'h0001},   // R7
        {4'd10, 16'h0001, 16'hFFFF, 16'h0000},   // R7
        {4'd11, 16'h8000, 16'h8000, 16'h0001},   // R8
        {4'd11, 16'hFFFF, 16'h0000, 16'h0000},   // R8
        {4'd12, 16'h0001, 16'hABCD, 16'h8000},   // R9
        {4'd12, 16'h1234, 16'h0000, 16'h2C48},   // R9
        {4'd13, 16'h1234, 16'hFFAB, 16'h34AB},   // R10
        {4'd14, 16'h1111, 16'hBEEF, 16'hBEEF},   // R11
        {4'd15, 16'h1111, 16'hBEEF, 16'h0000},   // R11
        {4'd9,  16'h8000, 16'h8000, 16'h0000}    // R7
    };

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0: return "R1";  4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd6: return "R4";
            4'd5, 4'd7: return "R5";
            4'd8: return "R6";
            4'd9, 4'd10: return "R7";
            4'd11: return "R8";  4'd12: return "R9";
            4'd13: return "R10";
            default: return "R11";
        endcase
    endfunction

    // behavioural reference, written bit by bit
    function automatic logic [15:0] model(input logic [3:0] o,
                                          input logic [15:0] x, input logic [15:0] y);
        logic [15:0] r;
        int n;
        n = int'(y[3:0]);
        r = x;
        case (o)
            4'd0: r = 16'(int'(x) + int'(y));
            4'd1: r = 16'(int'(y) - int'(x));
            4'd2: r = x | y;
            4'd3: r = x & y;
            4'd4: for (int i = 0; i < n; i++) r = {r[14:0], r[15]};
            4'd5: for (int i = 0; i < n; i++) r = {r[14:0], 1'b0};
            4'd6: for (int i = 0; i < n; i++) r = {r[0], r[15:1]};
            4'd7: for (int i = 0; i < n; i++) r = {r[15], r[15:1]};
            4'd8: r = (x == y) ? 16'd1 : 16'd0;
            4'd9: r = ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
            4'd10: r = ($signed(x) <= $signed(y)) ? 16'd1 : 16'd0;
            4'd11: r = ((int'(x) + int'(y)) > 65535) ? 16'd1 : 16'd0;
            4'd12: for (int i = 0; i < 16; i++) r[i] = x[15-i];
            4'd13: r = (x << 8) | {8'h00, y[7:0]};
            4'd14: r = y;
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    task automatic apply_check(input logic [3:0] o, input logic [15:0] x,
                               input logic [15:0] y, input logic [15:0] exp);
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag(o), o, x, y, res, exp);
        end
    endtask

    initial begin
        op = 4'd0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state after reset: zero operands add to zero (R1)
        @(negedge clk);
        checks++;
        if (res !== 16'h0000) begin
            fails++;
            $display("FAIL R1 idle actual=%h expected=%h", res, 16'h0000);
        end
        for (int v = 0; v < NV; v++)
            apply_check(VEC[v][51:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
        // R4 / R5: upper bits of the amount ignored
        apply_check(4'd6, 16'h00F0, 16'hABC4, 16'h000F);
        apply_check(4'd5, 16'h0001, 16'hFFF0, 16'h0001);
        // R9: operand B has no effect on reversal
        apply_check(4'd12, 16'h00FF, 16'hFFFF, 16'hFF00);
        // R7 extremes, R8 boundary
        apply_check(4'd10, 16'h8000, 16'h7FFF, 16'h0001);
        apply_check(4'd11, 16'h7FFF, 16'h8000, 16'h0000);
        apply_check(4'd11, 16'h8000, 16'h8001, 16'h0001);
        // random sweep over all codes against the reference
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  ro;
            logic [15:0] ra, rb;
            ro = 4'($urandom_range(0, 15));
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (k % 7 == 0) ra = 16'h8000;
            if (k % 11 == 0) rb = 16'h7FFF;
            apply_check(ro, ra, rb, model(ro, ra, rb));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule